// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This unit performs 32-bit integer multiplication and division for a simple RISC pipeline. An issue port takes an operation code and two source operands. No destination register is named. The unit then works through one bit per clock, and at the end it writes the outcome into a private pair of result registers called HI and LO. Multiplication leaves the 64-bit product split across the pair. Division leaves the quotient in LO and the remainder in HI.

A separate access port lets the pipeline copy HI or LO out to a general register, or load a general-register value into either half. While an operation is in flight the unit raises `busy_o`. A read request during that window is answered with `rd_valid_o` low, so the requester stalls and retries. Multiply and divide never signal overflow. Division by zero finishes in the normal time with a fixed result.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy_o` is 0, HI and LO both read as zero, and a read request is answered with `rd_valid_o` = 1.
- R2: `op_i` encodes 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide and 2'b11 unsigned divide. A `start_i` sampled while idle is accepted. `busy_o` is then 1 for exactly W (32) clock cycles after the accepting edge, and the results are visible when it falls.
- R3: A multiply forms the full 2W-bit product, signed or unsigned per `op_i[0]`, with the upper half in HI and the lower half in LO.
- R4: A divide puts the quotient in LO and the remainder in HI. Signed division truncates toward zero, and the remainder carries the sign of the dividend.
- R5: Dividing by zero completes in the usual W cycles with LO = all ones and HI = the original dividend, signed or unsigned.
- R6: A `start_i` raised while busy is dropped: the running operation keeps its operands, its opcode and its end time.
- R7: `rd_sel_i` = 0 reads LO and 1 reads HI on `rd_data_o`. `rd_valid_o` is 1 only when `rd_req_i` is 1 and the unit is idle.
- R8: With the unit idle, `wr_hi_i` or `wr_lo_i` loads `wr_data_i` into HI or LO at the next edge. While busy, both are ignored, even on the final cycle.
- R9: No operation overflows or faults. A signed divide of the most negative value by -1 returns LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Issue request |
| op_i | input | 2 | Operation code |
| src_a_i | input | W | Multiplicand or dividend |
| src_b_i | input | W | Multiplier or divisor |
| busy_o | output | 1 | Operation in flight |
| wr_hi_i | input | 1 | Load HI from wr_data_i |
| wr_lo_i | input | 1 | Load LO from wr_data_i |
| wr_data_i | input | W | Value to load |
| rd_req_i | input | 1 | Read request |
| rd_sel_i | input | 1 | 0 selects LO, 1 selects HI |
| rd_data_o | output | W | Selected register value |
| rd_valid_o | output | 1 | Read granted |

## Verification
The bench aims at the sign corners of both operations, where a magnitude-based datapath is most likely to go wrong. These include negative-by-positive products, a most-negative dividend, and division by -1 and by zero. A design with a missing or misplaced sign fix-up would return a wrong-signed quotient or remainder. It would also turn the zero-divisor dividend into its magnitude. Two other corners are a start and a register write that arrive mid-run or on the last busy cycle. A design that restarts on a stray start holds `busy_o` longer than 32 cycles. A design that lets a write win on the final edge leaves the written value in place of the result.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      MD_MUL_S = 2'b00,
      MD_MUL_U = 2'b01,
      MD_DIV_S = 2'b10,
      MD_DIV_U = 2'b11
   } md_op_e;

   function automatic logic is_div(input md_op_e op);
      return op[1];
   endfunction

   function automatic logic is_unsigned(input md_op_e op);
      return op[0];
   endfunction
endpackage

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           step_i,
   input  logic [W-1:0]   mcand_i,
   input  logic [W-1:0]   mplier_i,
   output logic [2*W-1:0] prod_nxt_o
);
   logic [W-1:0]   mcand_q;
   logic [2*W-1:0] acc_q;
   logic [W:0]     sum;

   always_comb begin
      sum        = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
      prod_nxt_o = {sum, acc_q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         acc_q   <= '0;
      end else if (load_i) begin
         mcand_q <= mcand_i;
         acc_q   <= {{W{1'b0}}, mplier_i};
      end else if (step_i) begin
         acc_q   <= prod_nxt_o;
      end
   end

   // R3: the multiplicand stays fixed through a run
   p_mcand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> $stable(mcand_q));
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic [W-1:0] quo_nxt_o,
   output logic [W-1:0] rem_nxt_o
);
   logic [W-1:0] dvs_q, rem_q, quo_q;
   logic [W:0]   shifted, diff;
   logic         fits;

   always_comb begin
      shifted   = {rem_q, quo_q[W-1]};
      diff      = shifted - {1'b0, dvs_q};
      fits      = !diff[W];
      rem_nxt_o = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_nxt_o = {quo_q[W-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvs_q <= '0;
         rem_q <= '0;
         quo_q <= '0;
      end else if (load_i) begin
         dvs_q <= dvs_i;
         rem_q <= '0;
         quo_q <= dvd_i;
      end else if (step_i) begin
         rem_q <= rem_nxt_o;
         quo_q <= quo_nxt_o;
      end
   end

   // R4: partial remainder stays below a nonzero divisor
   p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && dvs_q != '0) |=> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import muldiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] src_a_i,
   input  logic [W-1:0] src_b_i,
   output logic         busy_o,
   input  logic         wr_hi_i,
   input  logic         wr_lo_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         rd_req_i,
   input  logic         rd_sel_i,
   output logic [W-1:0] rd_data_o,
   output logic         rd_valid_o
);
   localparam int        CW   = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if (W < 4) begin : g_bad_width
         initial $error("muldiv_hilo: W must be at least 4");
      end
   endgenerate

   md_op_e        op_in, op_q;
   logic          busy_q, accept, last_step;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  hi_q, lo_q, a_raw_q;
   logic [W-1:0]  mag_a, mag_b;
   logic          sa, sb;
   logic          neg_res_q, neg_rem_q, dz_q;
   logic [2*W-1:0] prod_nxt, prod_fix;
   logic [W-1:0]  quo_nxt, rem_nxt, quo_fix, rem_fix;

   assign op_in     = md_op_e'(op_i);
   assign accept    = start_i && !busy_q;
   assign last_step = busy_q && (cnt_q == LAST);
   assign busy_o    = busy_q;

   always_comb begin
      sa    = !is_unsigned(op_in) && src_a_i[W-1];
      sb    = !is_unsigned(op_in) && src_b_i[W-1];
      mag_a = sa ? (~src_a_i + 1'b1) : src_a_i;
      mag_b = sb ? (~src_b_i + 1'b1) : src_b_i;
   end

   muldiv_mul_step #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n),
      .load_i(accept && !is_div(op_in)), .step_i(busy_q && !is_div(op_q)),
      .mcand_i(mag_a), .mplier_i(mag_b), .prod_nxt_o(prod_nxt)
   );

   muldiv_div_step #(.W(W)) u_div (
      .clk(clk), .rst_n(rst_n),
      .load_i(accept && is_div(op_in)), .step_i(busy_q && is_div(op_q)),
      .dvd_i(mag_a), .dvs_i(mag_b),
      .quo_nxt_o(quo_nxt), .rem_nxt_o(rem_nxt)
   );

   always_comb begin
      prod_fix = neg_res_q ? (~prod_nxt + 1'b1) : prod_nxt;
      quo_fix  = neg_res_q ? (~quo_nxt + 1'b1) : quo_nxt;
      rem_fix  = neg_rem_q ? (~rem_nxt + 1'b1) : rem_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         op_q      <= MD_MUL_S;
         neg_res_q <= 1'b0;
         neg_rem_q <= 1'b0;
         dz_q      <= 1'b0;
         a_raw_q   <= '0;
      end else if (accept) begin
         busy_q    <= 1'b1;
         cnt_q     <= '0;
         op_q      <= op_in;
         neg_res_q <= sa ^ sb;
         neg_rem_q <= sa;
         dz_q      <= (src_b_i == '0);
         a_raw_q   <= src_a_i;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (last_step) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (last_step) begin
         if (!is_div(op_q)) begin
            hi_q <= prod_fix[2*W-1:W];
            lo_q <= prod_fix[W-1:0];
         end else if (dz_q) begin
            hi_q <= a_raw_q;
            lo_q <= '1;
         end else begin
            hi_q <= rem_fix;
            lo_q <= quo_fix;
         end
      end else if (!busy_q) begin
         if (wr_hi_i) hi_q <= wr_data_i;
         if (wr_lo_i) lo_q <= wr_data_i;
      end
   end

   assign rd_data_o  = rd_sel_i ? hi_q : lo_q;
   assign rd_valid_o = rd_req_i && !busy_q;

   // R2: an idle start raises busy on the next cycle
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   // R2: busy only ends after the final count
   p_end_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(cnt_q) == LAST));
   // R6: the step counter advances by one while running
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (cnt_q == $past(cnt_q) + 1'b1));
   // R8: HI and LO hold while running, except at completion
   p_hold_hilo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q != LAST) |=> ($stable(hi_q) && $stable(lo_q)));
   // R5: a zero-divisor divide ends with LO all ones
   p_divzero_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_step && is_div(op_q) && dz_q) |=> (lo_q == '1));
endmodule

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = 2'b00;
   logic [W-1:0] src_a_i = '0, src_b_i = '0;
   logic         busy_o;
   logic         wr_hi_i = 1'b0, wr_lo_i = 1'b0;
   logic [W-1:0] wr_data_i = '0;
   logic         rd_req_i = 1'b0, rd_sel_i = 1'b0;
   logic [W-1:0] rd_data_o;
   logic         rd_valid_o;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   muldiv_hilo #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .busy_o(busy_o),
      .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i),
      .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_reg(input logic sel, output logic [W-1:0] val, output logic ok);
      rd_sel_i = sel;
      rd_req_i = 1'b1;
      #1;
      val = rd_data_o;
      ok  = rd_valid_o;
      rd_req_i = 1'b0;
   endtask

   function automatic logic [63:0] model(input logic [1:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
      longint sa, sb, q, r;
      logic [63:0] res;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (op)
         2'b00: res = 64'(sa * sb);
         2'b01: res = {32'h0, a} * {32'h0, b};
         default: begin
            if (b == '0) res = {a, 32'hFFFF_FFFF};
            else if (op == 2'b10) begin
               q = sa / sb; r = sa % sb;
               res = {r[31:0], q[31:0]};
            end else res = {a % b, a / b};
         end
      endcase
      return res;
   endfunction

   // issue at a negedge; returns right after the accepting edge
   task automatic issue(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      op_i = op; src_a_i = a; src_b_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_op(input string req, input logic [1:0] op,
                         input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] hi, lo;
      logic ok;
      logic [63:0] exp;
      exp = model(op, a, b);
      issue(op, a, b);
      repeat (W) @(negedge clk);
      read_reg(1'b1, hi, ok);
      read_reg(1'b0, lo, ok);
      check(req, {hi, lo}, exp);
   endtask

   task automatic t_reset;
      logic [W-1:0] v; logic ok;
      check("R1 busy", 64'(busy_o), 64'd0);
      read_reg(1'b1, v, ok);
      check("R1 hi", 64'(v), 64'd0);
      check("R1 valid", 64'(ok), 64'd1);
      read_reg(1'b0, v, ok);
      check("R1 lo", 64'(v), 64'd0);
   endtask

   task automatic t_busy_window;
      logic [W-1:0] v; logic ok;
      issue(2'b01, 32'd7, 32'd9);
      check("R2 busy after accept", 64'(busy_o), 64'd1);
      read_reg(1'b0, v, ok);
      check("R7 read stalled", 64'(ok), 64'd0);
      repeat (W - 1) @(negedge clk);
      check("R2 busy at cycle W-1", 64'(busy_o), 64'd1);
      @(negedge clk);
      check("R2 idle at cycle W", 64'(busy_o), 64'd0);
      read_reg(1'b0, v, ok);
      check("R2 result lo", 64'(v), 64'd63);
      check("R7 read granted", 64'(ok), 64'd1);
   endtask

   task automatic t_start_ignored;
      logic [W-1:0] hi, lo; logic ok;
      issue(2'b00, 32'hFFFF_FFFD, 32'd5);
      repeat (10) @(negedge clk);
      op_i = 2'b11; src_a_i = 32'd100; src_b_i = 32'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (W - 12) @(negedge clk);
      check("R6 busy end unchanged", 64'(busy_o), 64'd1);
      @(negedge clk);
      check("R6 done on time", 64'(busy_o), 64'd0);
      read_reg(1'b1, hi, ok);
      read_reg(1'b0, lo, ok);
      check("R6 original result", {hi, lo}, model(2'b00, 32'hFFFF_FFFD, 32'd5));
   endtask

   task automatic t_writes;
      logic [W-1:0] v; logic ok;
      @(negedge clk);
      wr_hi_i = 1'b1; wr_data_i = 32'hA5A5_0001;
      @(negedge clk);
      wr_hi_i = 1'b0; wr_lo_i = 1'b1; wr_data_i = 32'h0000_BEEF;
      @(negedge clk);
      wr_lo_i = 1'b0;
      read_reg(1'b1, v, ok);
      check("R8 write hi", 64'(v), 64'hA5A5_0001);
      read_reg(1'b0, v, ok);
      check("R8 write lo", 64'(v), 64'h0000_BEEF);
      // write during the last busy cycle must lose to the result
      issue(2'b01, 32'd3, 32'd4);
      repeat (W - 1) @(negedge clk);
      wr_hi_i = 1'b1; wr_lo_i = 1'b1; wr_data_i = 32'hDEAD_DEAD;
      @(negedge clk);
      wr_hi_i = 1'b0; wr_lo_i = 1'b0;
      read_reg(1'b0, v, ok);
      check("R8 busy write ignored lo", 64'(v), 64'd12);
      read_reg(1'b1, v, ok);
      check("R8 busy write ignored hi", 64'(v), 64'd0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_busy_window();
      run_op("R3 signed mul neg*pos", 2'b00, 32'hFFFF_FFF9, 32'd6);
      run_op("R3 signed mul neg*neg", 2'b00, 32'h8000_0000, 32'h8000_0000);
      run_op("R3 unsigned mul large", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op("R3 unsigned mul mixed", 2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
      run_op("R4 unsigned div", 2'b11, 32'd1000, 32'd7);
      run_op("R4 signed div neg/pos", 2'b10, 32'hFFFF_FFF9, 32'd2);
      run_op("R4 signed div pos/neg", 2'b10, 32'd7, 32'hFFFF_FFFE);
      run_op("R4 unsigned div high", 2'b11, 32'hF000_0001, 32'h0000_0010);
      run_op("R5 signed div by zero", 2'b10, 32'hFFFF_FF00, 32'd0);
      run_op("R5 unsigned div by zero", 2'b11, 32'h0000_1234, 32'd0);
      run_op("R9 min div minus one", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
      t_start_ignored();
      t_writes();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule